// File: doc/BRIEF.md
# Halt and Auto-Wakeup Power Sequencer

This controller takes a small microcontroller into a low-power halt and back out. While the CPU runs, a halt instruction puts the device into auto-wakeup halt only if auto-wakeup is enabled and the ordinary active-halt mode is not selected. In that state only the low-speed wakeup RC oscillator runs. The main oscillator, the peripheral clocks and the CPU clock are gated, and the interrupt mask level reads binary 10. The watchdog keeps running through halt or stops for its duration, depending on an option bit that is captured at entry.

Three kinds of event end halt: a reset request, a tick from the auto-wakeup timer, and a wake-capable external interrupt line. When one of them is accepted, the RC oscillator stops and the main oscillator and CPU clock restart. The peripherals stay gated while the oscillator comes up and then for a stabilisation delay of 256 or 4096 cycles. When the PLL option is set, they also wait for a PLL lock handshake. On release, the block gives a one-cycle indication to fetch the reset vector (reset cause) or to service an interrupt. For an interrupt it also presents the mask value to push and raises the mask to the interrupt's software priority until the pop.

Top module: `halt_awu_seq`

## Requirements
- R1: Halt is entered only on a cycle with halt_req=1, awu_en=1 and active_halt_en=0 while running. It is seen one cycle later as rc_osc_en=1.
- R2: wdg_active equals the wdg_halt_opt value sampled at halt entry for as long as halt lasts, and changes to wdg_halt_opt during halt have no effect. In every other state wdg_active is 1.
- R3: While halted: rc_osc_en=1, main_osc_en=0, periph_clk_en=0, cpu_clk_en=0 and cc_mask=2'b10.
- R4: Only sys_rst_req, awu_tick or an ext_irq bit that is set in WAKE_CAPABLE (default bits 0 and 2) ends halt. Other ext_irq bits are ignored.
- R5: One cycle after an accepted wake, rc_osc_en=0, main_osc_en=1, cpu_clk_en=1 and periph_clk_en=0. The delay count starts only after osc_run is seen high.
- R6: After osc_run is seen, periph_clk_en stays 0 for 256 cycles when delay_sel=0 and for 4096 cycles when delay_sel=1. With osc_run held high, there are 1+256 or 1+4096 gated cycles.
- R7: With pll_en=1, periph_clk_en stays 0 after the delay until pll_lock is seen high, then rises on the next cycle.
- R8: In the first cycle with all clocks enabled, exactly one one-cycle pulse appears: fetch_reset_vec if the cause was reset, service_irq otherwise.
- R9: sys_rst_req takes priority over a simultaneous interrupt wake. A sys_rst_req during the exit sequence restarts it from the oscillator wait with the reset cause.
- R10: With service_irq, push_mask shows the cpu_mask captured at halt entry. cc_mask equals the irq_prio captured at wake until an irq_pop, and then follows cpu_mask. Outside the halt sequence and interrupt service, cc_mask follows cpu_mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| halt_req | input | 1 | Halt instruction executed |
| awu_en | input | 1 | Auto-wakeup enable |
| active_halt_en | input | 1 | Ordinary active-halt mode selected |
| wdg_halt_opt | input | 1 | Watchdog keeps running in halt when 1 |
| sys_rst_req | input | 1 | Reset wake request |
| awu_tick | input | 1 | Auto-wakeup timer event |
| ext_irq | input | IRQ_W | Qualified external interrupt lines |
| irq_prio | input | 2 | Software priority of the waking interrupt |
| cpu_mask | input | 2 | Current mask level from the CPU |
| irq_pop | input | 1 | Condition code restored from stack |
| delay_sel | input | 1 | 0: 256-cycle delay, 1: 4096-cycle delay |
| pll_en | input | 1 | PLL option enabled |
| pll_lock | input | 1 | PLL startup finished |
| osc_run | input | 1 | Main oscillator running handshake |
| rc_osc_en | output | 1 | Wakeup RC oscillator enable |
| main_osc_en | output | 1 | Main oscillator enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| wdg_active | output | 1 | Watchdog may reset the device |
| cc_mask | output | 2 | Interrupt mask level |
| push_mask | output | 2 | Mask value to push on service |
| fetch_reset_vec | output | 1 | Pulse: fetch the reset vector |
| service_irq | output | 1 | Pulse: push state and service the interrupt |

## Verification
The hardest situation to reach is a reset request that arrives partway through a long stabilisation delay. The sequencer must then abandon the count, wait for the oscillator again and finish with the reset cause rather than the interrupt cause. To get there, the stimulus wakes the device with an interrupt, counts gated cycles at the ports and raises sys_rst_req at a fixed count inside the delay. It then expects the gated span to equal the cycles already spent plus a fresh full delay, followed by a reset-vector pulse. The PLL wait is reached the same way: pll_lock is raised only after a chosen number of cycles past the delay.

// File: rtl/halt_awu_pkg.sv
package halt_awu_pkg;

  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_HALT = 3'd1,
    ST_OSC  = 3'd2,
    ST_STAB = 3'd3,
    ST_PLL  = 3'd4
  } seq_st_e;

  localparam logic [1:0] HALT_MASK = 2'b10;

  function automatic int unsigned stab_cycles(input logic sel,
                                              input int unsigned short_len,
                                              input int unsigned long_len);
    return sel ? long_len : short_len;
  endfunction

endpackage

// File: rtl/awu_wake_qual.sv
module awu_wake_qual #(
  parameter int unsigned      IRQ_W        = 4,
  parameter logic [IRQ_W-1:0] WAKE_CAPABLE = 4'b0101
) (
  input  logic             sys_rst_req,
  input  logic             awu_tick,
  input  logic [IRQ_W-1:0] ext_irq,
  output logic             wake_any,
  output logic             wake_rst
);
  logic ext_hit;

  always_comb begin
    ext_hit  = |(ext_irq & WAKE_CAPABLE);
    wake_rst = sys_rst_req;
    wake_any = sys_rst_req | awu_tick | ext_hit;
  end
endmodule

// File: rtl/awu_stab_timer.sv
module awu_stab_timer
  import halt_awu_pkg::*;
#(
  parameter int unsigned SHORT_DLY = 256,
  parameter int unsigned LONG_DLY  = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sel,
  output logic done
);
  localparam int unsigned CNT_W = $clog2(LONG_DLY);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  always_comb begin
    last = CNT_W'(stab_cycles(sel, SHORT_DLY, LONG_DLY) - 1);
    done = run && (cnt_q == last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (!done)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/halt_awu_seq.sv
module halt_awu_seq
  import halt_awu_pkg::*;
#(
  parameter int unsigned      IRQ_W        = 4,
  parameter logic [IRQ_W-1:0] WAKE_CAPABLE = 4'b0101,
  parameter int unsigned      SHORT_DLY    = 256,
  parameter int unsigned      LONG_DLY     = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_req,
  input  logic             awu_en,
  input  logic             active_halt_en,
  input  logic             wdg_halt_opt,
  input  logic             sys_rst_req,
  input  logic             awu_tick,
  input  logic [IRQ_W-1:0] ext_irq,
  input  logic [1:0]       irq_prio,
  input  logic [1:0]       cpu_mask,
  input  logic             irq_pop,
  input  logic             delay_sel,
  input  logic             pll_en,
  input  logic             pll_lock,
  input  logic             osc_run,
  output logic             rc_osc_en,
  output logic             main_osc_en,
  output logic             periph_clk_en,
  output logic             cpu_clk_en,
  output logic             wdg_active,
  output logic [1:0]       cc_mask,
  output logic [1:0]       push_mask,
  output logic             fetch_reset_vec,
  output logic             service_irq
);
  seq_st_e    state_q, state_d;
  logic       cause_rst_q, cause_rst_d;
  logic       wdg_opt_q, wdg_opt_d;
  logic [1:0] saved_mask_q, saved_mask_d;
  logic [1:0] prio_q, prio_d;
  logic       in_isr_q, in_isr_d;
  logic       fetch_q, fetch_d;
  logic       svc_q, svc_d;

  // named internal events
  logic wake_any, wake_rst;
  logic stab_run, stab_done;
  logic enter_halt, in_exit, finish;

  awu_wake_qual #(.IRQ_W(IRQ_W), .WAKE_CAPABLE(WAKE_CAPABLE)) u_qual (
    .sys_rst_req (sys_rst_req),
    .awu_tick    (awu_tick),
    .ext_irq     (ext_irq),
    .wake_any    (wake_any),
    .wake_rst    (wake_rst)
  );

  awu_stab_timer #(.SHORT_DLY(SHORT_DLY), .LONG_DLY(LONG_DLY)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (stab_run),
    .sel   (delay_sel),
    .done  (stab_done)
  );

  always_comb begin
    enter_halt = (state_q == ST_RUN) && halt_req && awu_en && !active_halt_en;
    in_exit    = (state_q == ST_OSC) || (state_q == ST_STAB) || (state_q == ST_PLL);
    stab_run   = (state_q == ST_STAB) && !sys_rst_req;
    finish     = !sys_rst_req &&
                 (((state_q == ST_STAB) && stab_done && !pll_en) ||
                  ((state_q == ST_PLL) && pll_lock));
  end

  always_comb begin
    state_d      = state_q;
    cause_rst_d  = cause_rst_q;
    wdg_opt_d    = wdg_opt_q;
    saved_mask_d = saved_mask_q;
    prio_d       = prio_q;
    in_isr_d     = in_isr_q;
    fetch_d      = 1'b0;
    svc_d        = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (irq_pop) in_isr_d = 1'b0;
        if (enter_halt) begin
          state_d      = ST_HALT;
          wdg_opt_d    = wdg_halt_opt;
          saved_mask_d = cpu_mask;
          in_isr_d     = 1'b0;
        end
      end
      ST_HALT: begin
        if (wake_any) begin
          state_d     = ST_OSC;
          cause_rst_d = wake_rst;
          prio_d      = irq_prio;
        end
      end
      ST_OSC, ST_STAB, ST_PLL: begin
        if (sys_rst_req) begin
          state_d     = ST_OSC;
          cause_rst_d = 1'b1;
        end else if (state_q == ST_OSC) begin
          if (osc_run) state_d = ST_STAB;
        end else if (state_q == ST_STAB) begin
          if (stab_done && pll_en) state_d = ST_PLL;
        end
        if (finish) begin
          state_d  = ST_RUN;
          fetch_d  = cause_rst_q;
          svc_d    = !cause_rst_q;
          in_isr_d = !cause_rst_q;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_RUN;
      cause_rst_q  <= 1'b0;
      wdg_opt_q    <= 1'b1;
      saved_mask_q <= '0;
      prio_q       <= '0;
      in_isr_q     <= 1'b0;
      fetch_q      <= 1'b0;
      svc_q        <= 1'b0;
    end else begin
      state_q      <= state_d;
      cause_rst_q  <= cause_rst_d;
      wdg_opt_q    <= wdg_opt_d;
      saved_mask_q <= saved_mask_d;
      prio_q       <= prio_d;
      in_isr_q     <= in_isr_d;
      fetch_q      <= fetch_d;
      svc_q        <= svc_d;
    end
  end

  always_comb begin
    rc_osc_en       = (state_q == ST_HALT);
    main_osc_en     = (state_q != ST_HALT);
    cpu_clk_en      = (state_q != ST_HALT);
    periph_clk_en   = (state_q == ST_RUN);
    wdg_active      = (state_q == ST_HALT) ? wdg_opt_q : 1'b1;
    push_mask       = saved_mask_q;
    fetch_reset_vec = fetch_q;
    service_irq     = svc_q;
    if (state_q != ST_RUN) cc_mask = HALT_MASK;
    else if (in_isr_q)     cc_mask = prio_q;
    else                   cc_mask = cpu_mask;
  end
endmodule

// File: rtl/halt_awu_seq_chk.sv
module halt_awu_seq_chk #(
  parameter int unsigned      IRQ_W        = 4,
  parameter logic [IRQ_W-1:0] WAKE_CAPABLE = 4'b0101
) (
  input logic             clk,
  input logic             rst_n,
  input logic             halt_req,
  input logic             awu_en,
  input logic             active_halt_en,
  input logic             sys_rst_req,
  input logic             awu_tick,
  input logic [IRQ_W-1:0] ext_irq,
  input logic             rc_osc_en,
  input logic             main_osc_en,
  input logic             periph_clk_en,
  input logic             cpu_clk_en,
  input logic             wdg_active,
  input logic [1:0]       cc_mask,
  input logic             fetch_reset_vec,
  input logic             service_irq,
  input logic             in_exit,
  input logic             cause_rst
);
  // R1
  halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rc_osc_en) |-> $past(halt_req && awu_en && !active_halt_en));

  // R2
  wdg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rc_osc_en && $past(rc_osc_en)) |-> $stable(wdg_active));

  // R3
  halt_gating_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rc_osc_en |-> (!main_osc_en && !cpu_clk_en && !periph_clk_en && cc_mask == 2'b10));

  // R4
  wake_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rc_osc_en) |-> $past(sys_rst_req || awu_tick || (|(ext_irq & WAKE_CAPABLE))));

  // R5
  exit_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rc_osc_en) |-> (main_osc_en && cpu_clk_en && !periph_clk_en));

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(periph_clk_en) |-> (fetch_reset_vec ^ service_irq));

  // R8
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_reset_vec || service_irq) |=> !(fetch_reset_vec || service_irq));

  // R9
  rst_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exit && sys_rst_req) |=> (in_exit && cause_rst && !periph_clk_en));

  // R9
  rst_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rc_osc_en && sys_rst_req) |=> cause_rst);
endmodule

bind halt_awu_seq halt_awu_seq_chk #(.IRQ_W(IRQ_W), .WAKE_CAPABLE(WAKE_CAPABLE)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .halt_req        (halt_req),
  .awu_en          (awu_en),
  .active_halt_en  (active_halt_en),
  .sys_rst_req     (sys_rst_req),
  .awu_tick        (awu_tick),
  .ext_irq         (ext_irq),
  .rc_osc_en       (rc_osc_en),
  .main_osc_en     (main_osc_en),
  .periph_clk_en   (periph_clk_en),
  .cpu_clk_en      (cpu_clk_en),
  .wdg_active      (wdg_active),
  .cc_mask         (cc_mask),
  .fetch_reset_vec (fetch_reset_vec),
  .service_irq     (service_irq),
  .in_exit         (in_exit),
  .cause_rst       (cause_rst_q)
);

// File: tb/halt_awu_seq_test.sv
module halt_awu_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 0, awu_en = 0, active_halt_en = 0, wdg_halt_opt = 1;
  logic sys_rst_req = 0, awu_tick = 0;
  logic [3:0] ext_irq = '0;
  logic [1:0] irq_prio = 2'b00, cpu_mask = 2'b00;
  logic irq_pop = 0, delay_sel = 0, pll_en = 0, pll_lock = 0, osc_run = 1;
  logic rc_osc_en, main_osc_en, periph_clk_en, cpu_clk_en, wdg_active;
  logic [1:0] cc_mask, push_mask;
  logic fetch_reset_vec, service_irq;

  int checks = 0;
  int errors = 0;
  localparam int PLL_X = 7;

  always #10 clk = ~clk;

  halt_awu_seq uut (.*);

  // vector fields: {src[1:0], delay_sel, pll_en, expect_reset_cause}
  // src 0: reset, 1: wakeup tick, 2: capable ext line, 3: reset + ext line
  localparam logic [4:0] VEC [6] = '{
    5'b00_0_0_1, 5'b01_0_0_0, 5'b10_1_0_0,
    5'b11_0_1_1, 5'b01_1_1_0, 5'b10_0_1_0
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic enter_halt();
    @(negedge clk);
    halt_req = 1; awu_en = 1; active_halt_en = 0;
    @(negedge clk);
    halt_req = 0;
  endtask

  // counts gated cycles (cpu on, periph off); may inject reset at count rst_at
  task automatic run_exit(input int rst_at, output int gated);
    gated = 0;
    while (!periph_clk_en) begin
      if (cpu_clk_en && !periph_clk_en) gated++;
      sys_rst_req = (gated == rst_at);
      pll_lock = (gated >= 1 + (delay_sel ? 4096 : 256) + PLL_X) && (rst_at < 0);
      @(negedge clk);
      sys_rst_req = 0;
      if (gated > 10000) break;
    end
    pll_lock = 0;
  endtask

  initial begin
    #4000000;
    errors++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int g;
    int exp_g;
    #35 rst_n = 1;
    @(negedge clk);
    chk(periph_clk_en && cpu_clk_en && main_osc_en && !rc_osc_en && wdg_active,
        "R3 reset state", periph_clk_en, 1);

    // table walk
    foreach (VEC[i]) begin
      cpu_mask = 2'b01; irq_prio = 2'b11;
      delay_sel = VEC[i][2]; pll_en = VEC[i][1];
      enter_halt();
      chk(rc_osc_en && !main_osc_en && !cpu_clk_en && !periph_clk_en && cc_mask == 2'b10,
          "R3 halt outputs", cc_mask, 2);
      case (VEC[i][4:3])
        2'd0: sys_rst_req = 1;
        2'd1: awu_tick = 1;
        2'd2: ext_irq = VEC[i][2] ? 4'b0100 : 4'b0001;
        default: begin sys_rst_req = 1; ext_irq = 4'b0100; end
      endcase
      @(negedge clk);
      sys_rst_req = 0; awu_tick = 0; ext_irq = '0;
      chk(!rc_osc_en && main_osc_en && cpu_clk_en && !periph_clk_en, "R5 exit stage",
          rc_osc_en, 0);
      run_exit(-1, g);
      exp_g = 1 + (VEC[i][2] ? 4096 : 256) + (VEC[i][1] ? PLL_X : 0);
      chk(g == exp_g, VEC[i][1] ? "R7 pll gated cycles" : "R6 gated cycles", g, exp_g);
      chk(fetch_reset_vec == VEC[i][0] && service_irq == !VEC[i][0],
          VEC[i][4:3] == 2'd3 ? "R9 reset priority" : "R8 cause pulse",
          fetch_reset_vec, VEC[i][0]);
      if (!VEC[i][0]) begin
        chk(push_mask == 2'b01 && cc_mask == 2'b11, "R10 push and priority", cc_mask, 3);
        irq_pop = 1;
        @(negedge clk);
        irq_pop = 0;
        chk(cc_mask == 2'b01, "R10 mask restore", cc_mask, 1);
      end else begin
        @(negedge clk);
        chk(cc_mask == cpu_mask, "R10 mask after reset cause", cc_mask, cpu_mask);
      end
      chk(!fetch_reset_vec && !service_irq, "R8 one-cycle pulse", service_irq, 0);
    end

    // R1: entry blocked by active-halt or disabled auto-wakeup
    @(negedge clk);
    halt_req = 1; awu_en = 1; active_halt_en = 1;
    @(negedge clk);
    chk(!rc_osc_en && periph_clk_en, "R1 active-halt blocks", rc_osc_en, 0);
    awu_en = 0; active_halt_en = 0;
    @(negedge clk);
    halt_req = 0;
    chk(!rc_osc_en && periph_clk_en, "R1 awu disabled blocks", rc_osc_en, 0);

    // R2: option latched at entry
    delay_sel = 0; pll_en = 0;
    wdg_halt_opt = 0;
    enter_halt();
    chk(wdg_active == 0, "R2 watchdog off in halt", wdg_active, 0);
    wdg_halt_opt = 1;
    repeat (3) @(negedge clk);
    chk(wdg_active == 0, "R2 option change ignored", wdg_active, 0);

    // R4: non-capable lines ignored
    ext_irq = 4'b1010;
    repeat (3) @(negedge clk);
    ext_irq = '0;
    chk(rc_osc_en && !cpu_clk_en, "R4 ignored line", rc_osc_en, 1);

    // R9: reset mid-delay restarts with reset cause; osc_run handshake (R5)
    osc_run = 0;
    awu_tick = 1;
    @(negedge clk);
    awu_tick = 0;
    chk(wdg_active == 1, "R2 watchdog back on", wdg_active, 1);
    repeat (4) @(negedge clk);
    chk(!periph_clk_en && cpu_clk_en, "R5 waits for osc_run", periph_clk_en, 0);
    osc_run = 1;
    run_exit(101 - 5, g);
    exp_g = 1 + (101 - 5) + 256;
    chk(g == exp_g, "R9 restart gated cycles", g, exp_g);
    chk(fetch_reset_vec && !service_irq, "R9 reset cause after restart", fetch_reset_vec, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule